// File: doc/BRIEF.md
# Two-Floor Elevator Controller

This block sequences an elevator car that serves a lower and an upper floor. It takes a call button in each hall, a floor button inside the car for each floor, a door-open button inside the car, and a sensor pulse that marks arrival at a floor. For each floor it keeps a request flag that stays set until the car is resting at that floor with its door open.

The controller has six states. The state register drives the three outputs directly: door closed, car moving and direction down. No separate decode stage sits between the state and these outputs. The clock is slow: one period is how long the door stays open, nominally ten seconds.

A request flag is cleared by the same resting state that opens the door at its floor. The door-open button and the car buttons take effect only when they point the way the direction output allows.

Top module: `lift_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs become door open, stopped and direction up (`{door_closed, moving, going_down}` = 000), and both request flags become clear (`pend` = 00, `pend_n` = 11).
- R2: `{door_closed, moving, going_down}` only ever takes one of six values:
  - 000: rest low
  - 100: wait low
  - 110: rising
  - 001: rest high
  - 101: wait high
  - 111: falling
- R3: From rest low the next state is rising if the upper request is set, else wait low. From rest high the next state is falling if the lower request is set, else wait high.
- R4: From wait low the next state is chosen as follows, with the upper request taking priority:
  - rising if the upper request is set;
  - otherwise rest low if the lower request is set;
  - otherwise wait low.
- R5: From wait high the next state is chosen as follows, with the lower request taking priority:
  - falling if the lower request is set;
  - otherwise rest high if the upper request is set;
  - otherwise wait high.
- R6: Rising and falling hold until `arrive` is high at an edge. Rising then goes to rest high, and falling goes to rest low.
- R7: The lower request flag `pend[0]` is set by any of:
  - `hall_call[0]`;
  - `open_btn` while `going_down` = 0;
  - `car_call[0]` while `going_down` = 1.

  The upper request flag `pend[1]` is set by any of:
  - `hall_call[1]`;
  - `open_btn` while `going_down` = 1;
  - `car_call[1]` while `going_down` = 0.

  Any other button press leaves the flags unchanged.
- R8: `pend[0]` clears at an edge where the state is rest low, and `pend[1]` clears at an edge where the state is rest high. A set condition in that same cycle wins over the clear. Outside these cases each flag keeps its value.
- R9: `pend_n` is always the bitwise complement of `pend`.
- R10: A button press changes `pend` at the first edge. The sequencer acts on that flag one edge later, so a request made in a wait state moves the state at the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is the door dwell time |
| rst | input | 1 | Synchronous reset, active high |
| hall_call | input | 2 | Hall call buttons, bit 0 lower floor, bit 1 upper floor |
| car_call | input | 2 | In-car floor buttons, bit 0 lower, bit 1 upper |
| open_btn | input | 1 | In-car door-open button |
| arrive | input | 1 | Floor-arrival sensor |
| door_closed | output | 1 | 0 door open, 1 door closed |
| moving | output | 1 | 0 waiting, 1 travelling |
| going_down | output | 1 | 0 up, 1 down |
| pend | output | 2 | Request flags, bit 0 lower floor, bit 1 upper floor |
| pend_n | output | 2 | Complement of `pend` |

## Verification
Every flag and state output is a register, so a button press shows up in `pend` one edge after it is applied. Any state change it causes appears one edge after that. An `arrive` pulse moves the state at the very next edge. The bench drives inputs on the falling edge and steps one rising edge at a time. It compares outputs shortly after each rising edge, so every expected value is tied to a counted number of edges from its stimulus.

// File: rtl/lift_pkg.sv
package lift_pkg;

    localparam int NUM_FLOORS = 2;
    localparam int STATE_W    = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_REST_LO = 3'b000,
        ST_WAIT_LO = 3'b100,
        ST_RISING  = 3'b110,
        ST_REST_HI = 3'b001,
        ST_WAIT_HI = 3'b101,
        ST_FALLING = 3'b111
    } car_state_e;

    typedef struct packed {
        logic door_closed;
        logic moving;
        logic going_down;
    } car_out_t;

    typedef struct packed {
        logic hall;
        logic car;
    } floor_btn_t;

    function automatic car_out_t state_to_out(input car_state_e st);
        car_out_t o;
        o = car_out_t'(st);
        return o;
    endfunction

    // A floor's request is set by its hall call, by the door-open button
    // when the direction bit equals the floor index, or by its car button
    // when the direction bit differs from the floor index.
    function automatic logic call_set(input int unsigned floor_idx,
                                      input floor_btn_t   btn,
                                      input logic         open_b,
                                      input logic         dir_dn);
        logic sel;
        sel = (dir_dn == floor_idx[0]);
        return btn.hall | (open_b & sel) | (btn.car & ~sel);
    endfunction

    function automatic car_state_e rest_state_of(input int unsigned floor_idx);
        return floor_idx[0] ? ST_REST_HI : ST_REST_LO;
    endfunction

endpackage

// File: rtl/lift_call_latch.sv
module lift_call_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic q,
    output logic q_n
);
    logic q_r;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= 1'b0;
        else if (set_req)
            q_r <= 1'b1;
        else if (clr_req)
            q_r <= 1'b0;
    end

    assign q   = q_r;
    assign q_n = ~q_r;
endmodule

// File: rtl/lift_sequencer.sv
module lift_sequencer
    import lift_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_FLOORS-1:0] pend,
    input  logic                  arrive,
    output car_state_e            state
);
    car_state_e state_r, state_nx;
    logic want_lo, want_hi;

    assign want_lo = pend[0];
    assign want_hi = pend[1];

    always_comb begin
        state_nx = state_r;
        unique case (state_r)
            ST_REST_LO: state_nx = want_hi ? ST_RISING  : ST_WAIT_LO;
            ST_REST_HI: state_nx = want_lo ? ST_FALLING : ST_WAIT_HI;
            ST_RISING:  state_nx = arrive  ? ST_REST_HI : ST_RISING;
            ST_FALLING: state_nx = arrive  ? ST_REST_LO : ST_FALLING;
            ST_WAIT_LO: begin
                if (want_hi)      state_nx = ST_RISING;
                else if (want_lo) state_nx = ST_REST_LO;
                else              state_nx = ST_WAIT_LO;
            end
            ST_WAIT_HI: begin
                if (want_lo)      state_nx = ST_FALLING;
                else if (want_hi) state_nx = ST_REST_HI;
                else              state_nx = ST_WAIT_HI;
            end
            default:    state_nx = ST_REST_LO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_r <= ST_REST_LO;
        else     state_r <= state_nx;
    end

    assign state = state_r;
endmodule

// File: rtl/lift_ctrl.sv
module lift_ctrl
    import lift_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] hall_call,
    input  logic [1:0] car_call,
    input  logic       open_btn,
    input  logic       arrive,
    output logic       door_closed,
    output logic       moving,
    output logic       going_down,
    output logic [1:0] pend,
    output logic [1:0] pend_n
);
    car_state_e state;
    car_out_t   outs;

    assign outs = state_to_out(state);

    for (genvar f = 0; f < NUM_FLOORS; f++) begin : g_floor
        floor_btn_t btn;
        logic set_f, clr_f;

        assign btn.hall = hall_call[f];
        assign btn.car  = car_call[f];
        assign set_f    = call_set(f, btn, open_btn, outs.going_down);
        assign clr_f    = (state == rest_state_of(f));

        lift_call_latch u_latch (
            .clk     (clk),
            .rst     (rst),
            .set_req (set_f),
            .clr_req (clr_f),
            .q       (pend[f]),
            .q_n     (pend_n[f])
        );
    end

    lift_sequencer u_seq (
        .clk    (clk),
        .rst    (rst),
        .pend   (pend),
        .arrive (arrive),
        .state  (state)
    );

    assign door_closed = outs.door_closed;
    assign moving      = outs.moving;
    assign going_down  = outs.going_down;
endmodule

// File: rtl/lift_ctrl_chk.sv
module lift_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] hall_call,
    input logic       open_btn,
    input logic       arrive,
    input logic       door_closed,
    input logic       moving,
    input logic       going_down,
    input logic [1:0] pend
);
    logic [2:0] st;
    assign st = {door_closed, moving, going_down};

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (st == 3'b000 && pend == 2'b00)) else $error("reset"); // R1

    AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (rst)
        (st != 3'b010 && st != 3'b011)) else $error("encoding"); // R2

    AST_REST_LO_EXIT: assert property (@(posedge clk) disable iff (rst)
        (st == 3'b000) |=> (st == 3'b110 || st == 3'b100)) else $error("rest lo"); // R3

    AST_RISE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == 3'b110 && !arrive) |=> (st == 3'b110)) else $error("rise hold"); // R6

    AST_RISE_ARRIVE: assert property (@(posedge clk) disable iff (rst)
        (st == 3'b110 && arrive) |=> (st == 3'b001)) else $error("rise arrive"); // R6

    AST_LO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (st == 3'b000 && !hall_call[0] && !open_btn) |=> !pend[0]) else $error("lo clear"); // R8

    AST_HI_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (st == 3'b001 && !hall_call[1] && !open_btn) |=> !pend[1]) else $error("hi clear"); // R8
endmodule

bind lift_ctrl lift_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .hall_call   (hall_call),
    .open_btn    (open_btn),
    .arrive      (arrive),
    .door_closed (door_closed),
    .moving      (moving),
    .going_down  (going_down),
    .pend        (pend)
);

// File: tb/lift_ctrl_bench.sv
`timescale 1ns/1ps
module lift_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] hall_call = '0;
    logic [1:0] car_call  = '0;
    logic       open_btn  = 1'b0;
    logic       arrive    = 1'b0;
    logic       door_closed, moving, going_down;
    logic [1:0] pend, pend_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lift_ctrl u_lift_ctrl (
        .clk(clk), .rst(rst), .hall_call(hall_call), .car_call(car_call),
        .open_btn(open_btn), .arrive(arrive), .door_closed(door_closed),
        .moving(moving), .going_down(going_down), .pend(pend), .pend_n(pend_n)
    );

    localparam logic [2:0] REST_LO = 3'b000, WAIT_LO = 3'b100, RISING = 3'b110;
    localparam logic [2:0] REST_HI = 3'b001, WAIT_HI = 3'b101, FALLING = 3'b111;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_idle();
        @(negedge clk);
        hall_call = '0; car_call = '0; open_btn = 1'b0; arrive = 1'b0;
    endtask

    task automatic expect_out(input logic [2:0] st, input logic [1:0] pd, input string req);
        n_chk++;
        if ({door_closed, moving, going_down} !== st || pend !== pd || pend_n !== ~pd) begin
            n_fail++;
            $display("FAIL %s: state=%b pend=%b pend_n=%b expected state=%b pend=%b pend_n=%b",
                     req, {door_closed, moving, going_down}, pend, pend_n, st, pd, ~pd);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        expect_out(REST_LO, 2'b00, "R1 R9 reset");
        @(negedge clk) rst = 1'b0;
        step();
        expect_out(WAIT_LO, 2'b00, "R3 rest lo idle to wait");
        step(); step();
        expect_out(WAIT_LO, 2'b00, "R4 wait lo holds");
    endtask

    task automatic t_ignored_low();
        @(negedge clk) car_call = 2'b01;
        step();
        expect_out(WAIT_LO, 2'b00, "R7 lower car button ignored going up");
        drive_idle();
    endtask

    task automatic t_call_up();
        @(negedge clk) hall_call = 2'b10;
        step();
        expect_out(WAIT_LO, 2'b10, "R10 flag at first edge");
        drive_idle();
        step();
        expect_out(RISING, 2'b10, "R4 wait lo to rising");
        step(); step(); step();
        expect_out(RISING, 2'b10, "R6 rising holds");
        @(negedge clk) arrive = 1'b1;
        step();
        expect_out(REST_HI, 2'b10, "R6 arrive high");
        drive_idle();
        step();
        expect_out(WAIT_HI, 2'b00, "R8 R3 rest hi clears and waits");
    endtask

    task automatic t_high_side();
        @(negedge clk) car_call = 2'b10;
        step();
        expect_out(WAIT_HI, 2'b00, "R7 upper car button ignored going down");
        drive_idle();
        @(negedge clk) open_btn = 1'b1;
        step();
        expect_out(WAIT_HI, 2'b10, "R7 open sets upper when down");
        drive_idle();
        step();
        expect_out(REST_HI, 2'b10, "R5 wait hi reopens");
        step();
        expect_out(WAIT_HI, 2'b00, "R8 rest hi clear");
    endtask

    task automatic t_go_down();
        @(negedge clk) car_call = 2'b01;
        step();
        expect_out(WAIT_HI, 2'b01, "R7 lower car button when down");
        drive_idle();
        step();
        expect_out(FALLING, 2'b01, "R5 wait hi to falling");
        @(negedge clk) hall_call = 2'b10;
        step();
        expect_out(FALLING, 2'b11, "R6 falling holds, R7 hall sets");
        drive_idle();
        @(negedge clk) arrive = 1'b1;
        step();
        expect_out(REST_LO, 2'b11, "R6 arrive low");
        drive_idle();
        step();
        expect_out(RISING, 2'b10, "R3 rest lo to rising, R8 clear lower");
        @(negedge clk) arrive = 1'b1;
        step();
        expect_out(REST_HI, 2'b10, "R6 arrive high again");
        drive_idle();
        step();
        expect_out(WAIT_HI, 2'b00, "R3 rest hi to wait");
        @(negedge clk) hall_call = 2'b01;
        step();
        drive_idle();
        step();
        expect_out(FALLING, 2'b01, "R5 hall lower calls down");
        @(negedge clk) arrive = 1'b1;
        step();
        drive_idle();
        step();
        expect_out(WAIT_LO, 2'b00, "R8 R3 back to wait low");
    endtask

    task automatic t_low_side();
        @(negedge clk) open_btn = 1'b1;
        step();
        expect_out(WAIT_LO, 2'b01, "R7 open sets lower when up");
        drive_idle();
        step();
        expect_out(REST_LO, 2'b01, "R4 wait lo reopens");
        @(negedge clk) hall_call = 2'b01;
        step();
        expect_out(WAIT_LO, 2'b01, "R8 set wins over clear");
        drive_idle();
        step();
        expect_out(REST_LO, 2'b01, "R4 reopen again");
        step();
        expect_out(WAIT_LO, 2'b00, "R8 rest lo clear");
        @(negedge clk) hall_call = 2'b11;
        step();
        expect_out(WAIT_LO, 2'b11, "R7 both halls");
        drive_idle();
        step();
        expect_out(RISING, 2'b11, "R4 upper wins in wait low");
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog R1..: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_ignored_low();
        t_call_up();
        t_high_side();
        t_go_down();
        t_low_side();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule